// File: doc/BRIEF.md
# Receive/Transmit FIFO Controller with Character Timeout

This block holds the receive and transmit byte queues of a 16550-compatible serial port, together with the logic behind its queue control register. A register write port sets the control register, which enables the queues, clears either queue, selects a DMA mode flag and chooses the receive trigger level. The receive side takes bytes from a deserializer through a push strobe. Software drains it through reads of the receive buffer. The transmit side is filled by writes to the holding register and drained by a serializer through a pop strobe.

The block reports the byte count of each queue and the status bits that software polls: data ready, holding register empty, transmitter empty and a sticky overrun flag. It also reports whether the receive count has reached the selected trigger level. A character-time tick input drives a timeout counter that raises a pending flag when received bytes sit unread for four character times. With the queues disabled, each direction behaves as a single holding register. Framing, baud generation and interrupt priority are handled by neighbouring blocks.

Top module: `uart_fifo_ctl`

## Requirements
- R1: Each queue holds up to 16 bytes in a circular buffer, returns them in arrival order, and reports its fill count on `rx_count` / `tx_count`.
- R2: With the queues enabled, `fifo_ctl[7:6]` selects the receive trigger level (00 = 1 byte, 01 = 4, 10 = 8, 11 = 14), and `rx_trig` is high exactly when `rx_count` is at or above that level.
- R3: In the control byte, bit 0 enables the queues, bit 1 clears the receive queue, bit 2 clears the transmit queue and bit 3 is the DMA mode flag. Only the bits under mask 0xC9 are kept in `fifo_ctl`, so the clear bits read back as 0.
- R4: A control write that changes bit 0 empties both queues, as though bits 1 and 2 were also set.
- R5: Clearing the receive queue also stops the timeout counter and drops `timeout_pend`.
- R6: With the queues enabled, an accepted receive push, or a buffer read that leaves the receive queue non-empty, restarts the timeout at 4 character ticks. When the counter runs out, `timeout_pend` is set only if the receive queue still holds data.
- R7: A receive buffer read clears `timeout_pend`. `data_ready` stays high until the read that empties the receive queue.
- R8: A holding register write clears `thr_empty` and `tx_empty`. `thr_empty` returns when the transmit queue has drained. `tx_empty` returns only after `tx_done` reports that the last popped byte has left the shifter.
- R9: A read or pop from an empty queue returns 0x00 and leaves its count at 0.
- R10: A push into a full receive queue discards the byte and leaves the count unchanged. It sets the sticky `overrun` flag, which a line status read (`lsr_rd`) clears.
- R11: With bit 0 clear, each queue holds at most one byte and the timeout never becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control byte |
| thr_wr | input | 1 | Holding register write strobe |
| thr_wdata | input | DW | Byte to transmit |
| rbr_rd | input | 1 | Receive buffer read strobe |
| rbr_rdata | output | DW | Oldest received byte, 0x00 when empty |
| lsr_rd | input | 1 | Line status read strobe, clears overrun |
| rx_push | input | 1 | Received-byte strobe from the deserializer |
| rx_byte | input | DW | Received byte |
| tx_pop | input | 1 | Shifter takes the next byte |
| tx_byte | output | DW | Oldest queued transmit byte, 0x00 when empty |
| tx_done | input | 1 | Shifter finished its byte |
| char_tick | input | 1 | One pulse per character time |
| fifo_ctl | output | 8 | Retained control bits |
| rx_count | output | $clog2(DEPTH+1) | Receive fill count |
| tx_count | output | $clog2(DEPTH+1) | Transmit fill count |
| rx_trig | output | 1 | Receive count at or above trigger level |
| data_ready | output | 1 | Receive data available |
| thr_empty | output | 1 | Transmit queue empty |
| tx_empty | output | 1 | Transmit queue and shifter idle |
| overrun | output | 1 | Sticky receive overrun |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The bench builds the block with its defaults: a 16-byte depth, 8-bit data and a four-tick timeout. With these values, every trigger code can be swept against every fill level from 1 to 16, and each queue can be filled completely, overflowed and drained in order. The tick counts are short enough to step the timeout one tick at a time to its exact expiry, and to place reads and clears just before that point. The single-byte disabled mode is reached by toggling bit 0, which also exercises the flush on every transition.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int CTL_EN    = 0;
    localparam int CTL_RXCLR = 1;
    localparam int CTL_TXCLR = 2;
    localparam int CTL_DMA   = 3;
    localparam logic [7:0] CTL_KEEP = 8'hC9;

    typedef enum logic [1:0] {
        TRIG_ONE       = 2'b00,
        TRIG_QUARTER   = 2'b01,
        TRIG_HALF      = 2'b10,
        TRIG_NEAR_FULL = 2'b11
    } trig_sel_e;

    // Receive trigger level in bytes for a queue of the given depth.
    function automatic int trig_bytes(input trig_sel_e sel, input int depth);
        case (sel)
            TRIG_ONE:     return 1;
            TRIG_QUARTER: return depth / 4;
            TRIG_HALF:    return depth / 2;
            default:      return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_ring_fifo.sv
module uart_ring_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       cap_one,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            cnt;
    } ring_t;

    ring_t ring_d, ring_q;
    logic  empty, do_push, do_pop;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    assign empty = (ring_q.cnt == '0);
    assign full  = cap_one ? !empty : (ring_q.cnt == CW'(DEPTH));
    assign count = ring_q.cnt;
    assign rdata = empty ? '0 : ring_q.mem[ring_q.tail];

    always_comb begin
        ring_d  = ring_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            ring_d.mem[ring_q.head] = wdata;
            ring_d.head             = wrap_inc(ring_q.head);
        end
        if (do_pop) begin
            ring_d.tail = wrap_inc(ring_q.tail);
        end
        ring_d.cnt = ring_q.cnt + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            ring_d.head = '0;
            ring_d.tail = '0;
            ring_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

endmodule

// File: rtl/uart_char_timeout.sv
module uart_char_timeout #(
    parameter int CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cancel,
    input  logic restart,
    input  logic tick,
    input  logic clear_pend,
    input  logic data_present,
    output logic pend
);
    localparam int TW = $clog2(CHARS+1);

    typedef struct packed {
        logic [TW-1:0] left;
        logic          run;
        logic          pend;
    } tmo_t;

    tmo_t tmo_d, tmo_q;
    logic expire;

    assign pend = tmo_q.pend;

    always_comb begin
        tmo_d  = tmo_q;
        expire = 1'b0;
        if (tmo_q.run && tick) begin
            if (tmo_q.left == TW'(1)) begin
                tmo_d.run  = 1'b0;
                tmo_d.left = '0;
                expire     = 1'b1;
            end else begin
                tmo_d.left = tmo_q.left - TW'(1);
            end
        end
        if (expire && data_present) tmo_d.pend = 1'b1;
        if (restart) begin
            tmo_d.run  = 1'b1;
            tmo_d.left = TW'(CHARS);
        end
        if (clear_pend) tmo_d.pend = 1'b0;
        if (cancel) begin
            tmo_d.run  = 1'b0;
            tmo_d.left = '0;
            tmo_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmo_q <= '0;
        else        tmo_q <= tmo_d;
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int DW            = 8,
    parameter int TIMEOUT_CHARS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_wr,
    input  logic [7:0]                 ctl_wdata,
    input  logic                       thr_wr,
    input  logic [DW-1:0]              thr_wdata,
    input  logic                       rbr_rd,
    output logic [DW-1:0]              rbr_rdata,
    input  logic                       lsr_rd,
    input  logic                       rx_push,
    input  logic [DW-1:0]              rx_byte,
    input  logic                       tx_pop,
    output logic [DW-1:0]              tx_byte,
    input  logic                       tx_done,
    input  logic                       char_tick,
    output logic [7:0]                 fifo_ctl,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic                       rx_trig,
    output logic                       data_ready,
    output logic                       thr_empty,
    output logic                       tx_empty,
    output logic                       overrun,
    output logic                       timeout_pend
);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [7:0] ctl;
        logic       ovr;
        logic       shift_busy;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic          en, toggle, rx_flush, tx_flush;
    logic          rx_full, tx_full, rx_accept, tmo_restart;
    logic [CW-1:0] trig_level;

    assign en = st_q.ctl[CTL_EN];

    // Control write decode: an enable change forces both clears.
    assign toggle   = ctl_wr && (ctl_wdata[CTL_EN] != st_q.ctl[CTL_EN]);
    assign rx_flush = ctl_wr && (ctl_wdata[CTL_RXCLR] || toggle);
    assign tx_flush = ctl_wr && (ctl_wdata[CTL_TXCLR] || toggle);

    assign rx_accept   = rx_push && !rx_full;
    assign tmo_restart = en && (rx_accept || (rbr_rd && rx_count > CW'(1)));
    assign trig_level  = CW'(trig_bytes(trig_sel_e'(st_q.ctl[7:6]), DEPTH));

    uart_ring_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .cap_one (!en),
        .push    (rx_push),
        .pop     (rbr_rd),
        .wdata   (rx_byte),
        .rdata   (rbr_rdata),
        .count   (rx_count),
        .full    (rx_full)
    );

    uart_ring_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_flush),
        .cap_one (!en),
        .push    (thr_wr),
        .pop     (tx_pop),
        .wdata   (thr_wdata),
        .rdata   (tx_byte),
        .count   (tx_count),
        .full    (tx_full)
    );

    uart_char_timeout #(.CHARS(TIMEOUT_CHARS)) u_timeout (
        .clk          (clk),
        .rst_n        (rst_n),
        .cancel       (rx_flush),
        .restart      (tmo_restart),
        .tick         (char_tick),
        .clear_pend   (rbr_rd),
        .data_present (rx_count != '0),
        .pend         (timeout_pend)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_wr) st_d.ctl = ctl_wdata & CTL_KEEP;
        if (lsr_rd) st_d.ovr = 1'b0;
        if (rx_push && rx_full) st_d.ovr = 1'b1;
        if (tx_pop && tx_count != '0) st_d.shift_busy = 1'b1;
        else if (tx_done)             st_d.shift_busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fifo_ctl   = st_q.ctl;
    assign overrun    = st_q.ovr;
    assign data_ready = (rx_count != '0);
    assign rx_trig    = en ? (rx_count >= trig_level) : data_ready;
    assign thr_empty  = (tx_count == '0) && !tx_full;
    assign tx_empty   = thr_empty && !st_q.shift_busy;

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ctl_wr,
    input logic [7:0]                 ctl_wdata,
    input logic                       thr_wr,
    input logic                       rbr_rd,
    input logic [DW-1:0]              rbr_rdata,
    input logic                       rx_push,
    input logic                       tx_pop,
    input logic [DW-1:0]              tx_byte,
    input logic [7:0]                 fifo_ctl,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic [$clog2(DEPTH+1)-1:0] tx_count,
    input logic                       thr_empty,
    input logic                       tx_empty,
    input logic                       overrun,
    input logic                       timeout_pend
);
    localparam int CW = $clog2(DEPTH+1);

    logic rx_is_full;
    assign rx_is_full = fifo_ctl[0] ? (rx_count == CW'(DEPTH)) : (rx_count != '0);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH) && tx_count <= CW'(DEPTH));

    assert_ctl_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> fifo_ctl == ($past(ctl_wdata) & 8'hC9));

    assert_toggle_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && (ctl_wdata[0] != fifo_ctl[0]) |=> rx_count == '0 && tx_count == '0);

    assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_wdata[1] |=> rx_count == '0 && !timeout_pend);

    assert_pend_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pend) |-> rx_count != '0);

    assert_thr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr && !tx_pop && !ctl_wr |=> !thr_empty && !tx_empty);

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rbr_rd && rx_count == '0 |-> rbr_rdata == '0);

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop && tx_count == '0 |-> tx_byte == '0);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_is_full && !rbr_rd && !ctl_wr |=> overrun && $stable(rx_count));

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_wdata    (ctl_wdata),
    .thr_wr       (thr_wr),
    .rbr_rd       (rbr_rd),
    .rbr_rdata    (rbr_rdata),
    .rx_push      (rx_push),
    .tx_pop       (tx_pop),
    .tx_byte      (tx_byte),
    .fifo_ctl     (fifo_ctl),
    .rx_count     (rx_count),
    .tx_count     (tx_count),
    .thr_empty    (thr_empty),
    .tx_empty     (tx_empty),
    .overrun      (overrun),
    .timeout_pend (timeout_pend)
);

// File: tb/tb_uart_fifo_ctl.sv
module tb_uart_fifo_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH+1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0, thr_wr = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0;
    logic          rx_push = 1'b0, tx_pop = 1'b0, tx_done = 1'b0, char_tick = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic [DW-1:0] thr_wdata = '0, rx_byte = '0;
    logic [DW-1:0] rbr_rdata, tx_byte;
    logic [7:0]    fifo_ctl;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_trig, data_ready, thr_empty, tx_empty, overrun, timeout_pend;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_ctl #(.DEPTH(DEPTH), .DW(DW), .TIMEOUT_CHARS(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .thr_wr(thr_wr), .thr_wdata(thr_wdata),
        .rbr_rd(rbr_rd), .rbr_rdata(rbr_rdata),
        .lsr_rd(lsr_rd),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_done(tx_done),
        .char_tick(char_tick),
        .fifo_ctl(fifo_ctl), .rx_count(rx_count), .tx_count(tx_count),
        .rx_trig(rx_trig), .data_ready(data_ready), .thr_empty(thr_empty),
        .tx_empty(tx_empty), .overrun(overrun), .timeout_pend(timeout_pend)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Every task starts and ends at a falling edge.
    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; @(negedge clk); ctl_wr = 1'b0;
    endtask
    task automatic push_rx(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b; @(negedge clk); rx_push = 1'b0;
    endtask
    task automatic wr_thr(input logic [7:0] b);
        thr_wr = 1'b1; thr_wdata = b; @(negedge clk); thr_wr = 1'b0;
    endtask
    task automatic rd_rbr(output logic [7:0] b);
        b = rbr_rdata; rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0;
    endtask
    task automatic pop_tx(output logic [7:0] b);
        b = tx_byte; tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    endtask
    task automatic end_shift();
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    endtask
    task automatic rd_lsr();
        lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1; @(negedge clk); char_tick = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R3 reset ctl", fifo_ctl, 0);
        chk("R1 reset rx count", rx_count, 0);
        chk("R1 reset tx count", tx_count, 0);
        chk("R7 reset data_ready", data_ready, 0);
        chk("R8 reset thr_empty", thr_empty, 1);
        chk("R8 reset tx_empty", tx_empty, 1);
        chk("R10 reset overrun", overrun, 0);

        // R2: every trigger code against every fill level
        for (int t = 0; t < 4; t++) begin
            int lvl;
            logic [7:0] v;
            lvl = (t == 0) ? 1 : (t == 1) ? DEPTH/4 : (t == 2) ? DEPTH/2 : DEPTH-2;
            v = 8'(8'h03 | (t << 6));
            wr_ctl(v);
            chk("R3 retained bits", fifo_ctl, int'(v & 8'hC9));
            chk("R4 rx flushed", rx_count, 0);
            for (int k = 1; k <= DEPTH; k++) begin
                push_rx(8'(k));
                chk("R2 trigger", rx_trig, (k >= lvl) ? 1 : 0);
            end
            chk("R1 full count", rx_count, DEPTH);
        end

        // R10: push into a full queue
        chk("R10 overrun before", overrun, 0);
        push_rx(8'hEE);
        chk("R10 overrun set", overrun, 1);
        chk("R10 count held", rx_count, DEPTH);
        rd_lsr();
        chk("R10 overrun cleared", overrun, 0);

        // R1 order, R7 data_ready, R9 empty read
        wr_ctl(8'h03);
        for (int i = 0; i < DEPTH; i++) push_rx(8'((i * 37 + 5) & 8'hFF));
        for (int i = 0; i < DEPTH; i++) begin
            rd_rbr(b);
            chk("R1 order", b, (i * 37 + 5) & 8'hFF);
            chk("R7 data_ready", data_ready, (i < DEPTH - 1) ? 1 : 0);
        end
        rd_rbr(b);
        chk("R9 empty read value", b, 0);
        chk("R9 empty read count", rx_count, 0);

        // R6/R7: timeout
        push_rx(8'h11);
        push_rx(8'h22);
        ticks(3);
        chk("R6 not yet", timeout_pend, 0);
        ticks(1);
        chk("R6 expired", timeout_pend, 1);
        rd_rbr(b);
        chk("R7 read clears pend", timeout_pend, 0);
        chk("R7 still ready", data_ready, 1);
        ticks(3);
        chk("R6 restart by read", timeout_pend, 0);
        ticks(1);
        chk("R6 expired again", timeout_pend, 1);
        rd_rbr(b);
        chk("R7 ready cleared", data_ready, 0);
        ticks(4);
        chk("R6 empty never pends", timeout_pend, 0);

        // R5: receive clear stops the timer
        push_rx(8'h33);
        ticks(2);
        wr_ctl(8'h03);
        chk("R5 rx cleared", rx_count, 0);
        ticks(4);
        chk("R5 no pend after clear", timeout_pend, 0);
        push_rx(8'h44);
        ticks(4);
        chk("R5 pend before clear", timeout_pend, 1);
        wr_ctl(8'h03);
        chk("R5 clear drops pend", timeout_pend, 0);

        // R8/R9: transmit path
        for (int i = 0; i < 3; i++) wr_thr(8'(8'hA0 + i));
        chk("R8 thr_empty low", thr_empty, 0);
        chk("R8 tx_empty low", tx_empty, 0);
        chk("R1 tx count", tx_count, 3);
        for (int i = 0; i < 3; i++) begin
            pop_tx(b);
            chk("R1 tx order", b, 8'hA0 + i);
        end
        chk("R8 thr_empty after drain", thr_empty, 1);
        chk("R8 tx_empty waits shifter", tx_empty, 0);
        end_shift();
        chk("R8 tx_empty after done", tx_empty, 1);
        pop_tx(b);
        chk("R9 empty pop value", b, 0);
        chk("R9 empty pop count", tx_count, 0);
        chk("R9 empty pop keeps idle", tx_empty, 1);

        // R3: transmit-only clear leaves receive alone
        push_rx(8'h01);
        push_rx(8'h02);
        for (int i = 0; i < 3; i++) wr_thr(8'(i));
        wr_ctl(8'h05);
        chk("R3 tx clear", tx_count, 0);
        chk("R3 rx untouched", rx_count, 2);

        // R4/R11: disable flushes, then single-byte mode
        for (int i = 0; i < 2; i++) wr_thr(8'(i));
        wr_ctl(8'h00);
        chk("R4 disable flush rx", rx_count, 0);
        chk("R4 disable flush tx", tx_count, 0);
        chk("R3 ctl zero", fifo_ctl, 0);
        push_rx(8'h5A);
        push_rx(8'h6B);
        chk("R11 one byte held", rx_count, 1);
        chk("R11 overrun single", overrun, 1);
        wr_thr(8'h71);
        wr_thr(8'h72);
        chk("R11 tx one byte", tx_count, 1);
        ticks(6);
        chk("R11 no timeout", timeout_pend, 0);
        rd_rbr(b);
        chk("R11 first byte kept", b, 8'h5A);
        rd_lsr();

        // R3/R4: enabling with DMA flag, then all bits set
        push_rx(8'h10);
        wr_ctl(8'h09);
        chk("R3 dma kept", fifo_ctl, 8'h09);
        chk("R4 enable flush", rx_count, 0);
        chk("R4 enable flush tx", tx_count, 0);
        push_rx(8'h20);
        wr_ctl(8'hFF);
        chk("R3 mask", fifo_ctl, 8'hC9);
        chk("R3 self-clear bits flush", rx_count, 0);

        summary();
    end
endmodule